// File: doc/BRIEF.md
# IO Request Network Bridge

This block links a processor core's accesses to the uncached IO address range with the on-chip service network. A load or store aimed at that range is accepted from the core and placed in a short queue. Each queued access is then issued as one network message to the single tile that hosts the IO bridge to the outside world. The message is tagged with this tile's identity and the issuing hardware thread, so the answer can find its way back. Replies that arrive from the network go straight to the core one cycle later, with the thread and the returned data.

The same block can also serve IO requests that other tiles send to it. Such a request is held in a one-entry service slot and offered to a local device port. When the device answers, the block builds a reply message and sends it to the tile named as the source in the stored request. Only one such request is in progress at a time. Any further incoming request is left unconsumed on the network until the slot is free again.

The core must honour the availability flag. This flag drops while there is still headroom in the queue, so a request already in flight toward the block is not lost.

Top module: `io_msg_bridge`

## Requirements
- R1: After reset `core_avail` is 1, and `net_tx_valid`, `core_rsp_valid`, `net_rx_consumed` (with no input valid) and `svc_req_valid` are 0.
- R2: A message is packed MSB to LSB as {is_reply (1 bit), source tile (TILE_W), thread (THREAD_W), op (1 bit: 0 = load, 1 = store), address (ADDR_W), data (DATA_W)}. An outgoing request has is_reply = 0, source = TILE_ID, and the core's thread, op, address and data.
- R3: `core_avail` is 1 exactly while fewer than QUEUE_DEPTH-AF_MARGIN requests are queued. A `core_req_valid` seen while `core_avail` is 0 is dropped, and no message is ever produced for it.
- R4: Requests leave in acceptance order with `net_tx_dest` = HOST_TILE. Each one stays on `net_tx_valid`/`net_tx_msg`/`net_tx_dest` unchanged until the cycle in which `net_tx_consumed` is 1, and is removed in that cycle.
- R5: An incoming message with is_reply = 1 is consumed in the same cycle. In the next cycle `core_rsp_valid` pulses for one cycle, carrying the message's thread and data.
- R6: An incoming message with is_reply = 0 is consumed only when the service slot is empty. From the next cycle its thread, op, address and data are shown on the `svc_req_*` port, with `svc_req_valid` held at 1 until `svc_rsp_valid` is 1.
- R7: After the device answers, the reply message has is_reply = 1, source = TILE_ID, and the stored thread, op and address, with data = `svc_rsp_data`. It is sent with `net_tx_dest` equal to the stored request's source tile.
- R8: A pending reply is sent ahead of queued requests. The exception is a queued request that is already on the output and not yet consumed: that request goes first.
- R9: While the slot is busy, incoming requests are not consumed. A `svc_rsp_valid` seen while no request is waiting for the device has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core presents an IO access |
| core_req_thread | input | THREAD_W | Issuing thread |
| core_req_store | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | ADDR_W | Access address |
| core_req_data | input | DATA_W | Store data |
| core_avail | output | 1 | Queue can take another access |
| core_rsp_valid | output | 1 | Reply pulse to the core |
| core_rsp_thread | output | THREAD_W | Thread of the reply |
| core_rsp_data | output | DATA_W | Reply data |
| net_tx_valid | output | 1 | Outgoing message present |
| net_tx_dest | output | TILE_W | Destination tile |
| net_tx_msg | output | 2+TILE_W+THREAD_W+ADDR_W+DATA_W | Outgoing message |
| net_tx_consumed | input | 1 | Network takes the outgoing message |
| net_rx_valid | input | 1 | Incoming message present |
| net_rx_msg | input | 2+TILE_W+THREAD_W+ADDR_W+DATA_W | Incoming message |
| net_rx_consumed | output | 1 | Block takes the incoming message |
| svc_req_valid | output | 1 | Served request waiting for the device |
| svc_req_thread | output | THREAD_W | Thread of the served request |
| svc_req_store | output | 1 | Op of the served request |
| svc_req_addr | output | ADDR_W | Address of the served request |
| svc_req_data | output | DATA_W | Data of the served request |
| svc_rsp_valid | input | 1 | Device answers the served request |
| svc_rsp_data | input | DATA_W | Device answer data |

## Verification
A queue pointer or count that has gone wrong shows up as a message in the wrong order, a duplicate, or a missing one on `net_tx_msg`. It also shows up as a `core_avail` edge on the wrong push. Both are visible within one cycle of the push or pop that set the fault off. A corrupt service-slot state shows as a request that is consumed while the slot is busy, or a reply sent to the wrong tile. It can also show as a reply that is never sent at all, which the bench sees as `net_tx_valid` staying low in the cycle after the device answers. A wrong output-select hold flag makes the message change under an unconsumed output. The checker flags this on the very next cycle.

// File: rtl/io_bridge_pkg.sv
package io_bridge_pkg;
  // Service slot that serves IO requests arriving from other tiles.
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_DEV   = 2'd1,
    SLOT_REPLY = 2'd2
  } slot_state_t;
endpackage

// File: rtl/io_req_fifo.sv
module io_req_fifo #(
  parameter int DEPTH     = 4,
  parameter int WIDTH     = 40,
  parameter int AF_MARGIN = 1,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             almost_full,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] AF_LEVEL = CNT_W'(DEPTH - AF_MARGIN);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  assign head        = store[rd_ptr];
  assign empty       = (count == '0);
  assign almost_full = (count >= AF_LEVEL);
endmodule

// File: rtl/io_svc_slot.sv
module io_svc_slot
  import io_bridge_pkg::*;
#(
  parameter int TILE_W   = 4,
  parameter int THREAD_W = 2,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [TILE_W-1:0]   in_src,
  input  logic [THREAD_W-1:0] in_thread,
  input  logic                in_store,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                dev_done,
  input  logic [DATA_W-1:0]   dev_data,
  input  logic                reply_sent,
  output logic                idle,
  output logic                wait_dev,
  output logic                reply_pend,
  output logic [TILE_W-1:0]   s_src,
  output logic [THREAD_W-1:0] s_thread,
  output logic                s_store,
  output logic [ADDR_W-1:0]   s_addr,
  output logic [DATA_W-1:0]   s_data
);
  slot_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SLOT_IDLE;
      s_src    <= '0;
      s_thread <= '0;
      s_store  <= 1'b0;
      s_addr   <= '0;
      s_data   <= '0;
    end else begin
      unique case (state)
        SLOT_IDLE: if (take) begin
          state    <= SLOT_DEV;
          s_src    <= in_src;
          s_thread <= in_thread;
          s_store  <= in_store;
          s_addr   <= in_addr;
          s_data   <= in_data;
        end
        SLOT_DEV: if (dev_done) begin
          state  <= SLOT_REPLY;
          s_data <= dev_data;
        end
        SLOT_REPLY: if (reply_sent) state <= SLOT_IDLE;
        default: state <= SLOT_IDLE;
      endcase
    end
  end

  assign idle       = (state == SLOT_IDLE);
  assign wait_dev   = (state == SLOT_DEV);
  assign reply_pend = (state == SLOT_REPLY);
endmodule

// File: rtl/io_rsp_reg.sv
module io_rsp_reg #(
  parameter int THREAD_W = 2,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [THREAD_W-1:0] in_thread,
  input  logic [DATA_W-1:0]   in_data,
  output logic                out_valid,
  output logic [THREAD_W-1:0] out_thread,
  output logic [DATA_W-1:0]   out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_thread <= '0;
      out_data   <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_thread <= in_thread;
        out_data   <= in_data;
      end
    end
  end
endmodule

// File: rtl/io_msg_bridge.sv
module io_msg_bridge #(
  parameter int TILE_W      = 4,
  parameter int THREAD_W    = 2,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int QUEUE_DEPTH = 4,
  parameter int AF_MARGIN   = 1,
  parameter int TILE_ID     = 3,
  parameter int HOST_TILE   = 0
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     core_req_valid,
  input  logic [THREAD_W-1:0]                      core_req_thread,
  input  logic                                     core_req_store,
  input  logic [ADDR_W-1:0]                        core_req_addr,
  input  logic [DATA_W-1:0]                        core_req_data,
  output logic                                     core_avail,
  output logic                                     core_rsp_valid,
  output logic [THREAD_W-1:0]                      core_rsp_thread,
  output logic [DATA_W-1:0]                        core_rsp_data,
  output logic                                     net_tx_valid,
  output logic [TILE_W-1:0]                        net_tx_dest,
  output logic [1+TILE_W+THREAD_W+ADDR_W+DATA_W:0] net_tx_msg,
  input  logic                                     net_tx_consumed,
  input  logic                                     net_rx_valid,
  input  logic [1+TILE_W+THREAD_W+ADDR_W+DATA_W:0] net_rx_msg,
  output logic                                     net_rx_consumed,
  output logic                                     svc_req_valid,
  output logic [THREAD_W-1:0]                      svc_req_thread,
  output logic                                     svc_req_store,
  output logic [ADDR_W-1:0]                        svc_req_addr,
  output logic [DATA_W-1:0]                        svc_req_data,
  input  logic                                     svc_rsp_valid,
  input  logic [DATA_W-1:0]                        svc_rsp_data
);
  localparam int MSG_W  = 2 + TILE_W + THREAD_W + ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(QUEUE_DEPTH + 1);
  localparam int A_LSB  = DATA_W;
  localparam int OP_BIT = DATA_W + ADDR_W;
  localparam int T_LSB  = OP_BIT + 1;
  localparam int S_LSB  = T_LSB + THREAD_W;
  localparam int R_BIT  = MSG_W - 1;
  localparam logic [TILE_W-1:0] OWN_ID  = TILE_W'(TILE_ID);
  localparam logic [TILE_W-1:0] HOST_ID = TILE_W'(HOST_TILE);

  function automatic logic [MSG_W-1:0] pack_msg(
    input logic r, input logic [TILE_W-1:0] s, input logic [THREAD_W-1:0] t,
    input logic o, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    return {r, s, t, o, a, d};
  endfunction

  // Incoming message fields
  logic                rx_is_reply;
  logic [TILE_W-1:0]   rx_src;
  logic [THREAD_W-1:0] rx_thread;
  logic                rx_store;
  logic [ADDR_W-1:0]   rx_addr;
  logic [DATA_W-1:0]   rx_data;
  assign rx_is_reply = net_rx_msg[R_BIT];
  assign rx_src      = net_rx_msg[S_LSB +: TILE_W];
  assign rx_thread   = net_rx_msg[T_LSB +: THREAD_W];
  assign rx_store    = net_rx_msg[OP_BIT];
  assign rx_addr     = net_rx_msg[A_LSB +: ADDR_W];
  assign rx_data     = net_rx_msg[0 +: DATA_W];

  // Named internal events
  logic             fifo_push, fifo_pop, fifo_empty, fifo_af;
  logic [CNT_W-1:0] fifo_count;
  logic [MSG_W-1:0] fifo_head;
  logic             slot_idle, slot_wait, reply_pend, reply_sent;
  logic             rsp_take, req_take, sel_reply, hold_fifo;
  logic [TILE_W-1:0]   s_src;
  logic [THREAD_W-1:0] s_thread;
  logic                s_store;
  logic [ADDR_W-1:0]   s_addr;
  logic [DATA_W-1:0]   s_data;

  assign core_avail = !fifo_af;
  assign fifo_push  = core_req_valid && core_avail;

  io_req_fifo #(.DEPTH(QUEUE_DEPTH), .WIDTH(MSG_W), .AF_MARGIN(AF_MARGIN)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push),
    .push_data(pack_msg(1'b0, OWN_ID, core_req_thread, core_req_store,
                        core_req_addr, core_req_data)),
    .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty),
    .almost_full(fifo_af), .count(fifo_count));

  assign rsp_take        = net_rx_valid && rx_is_reply;
  assign req_take        = net_rx_valid && !rx_is_reply && slot_idle;
  assign net_rx_consumed = rsp_take || req_take;

  io_rsp_reg #(.THREAD_W(THREAD_W), .DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .take(rsp_take), .in_thread(rx_thread),
    .in_data(rx_data), .out_valid(core_rsp_valid), .out_thread(core_rsp_thread),
    .out_data(core_rsp_data));

  io_svc_slot #(.TILE_W(TILE_W), .THREAD_W(THREAD_W), .ADDR_W(ADDR_W),
                .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .take(req_take), .in_src(rx_src),
    .in_thread(rx_thread), .in_store(rx_store), .in_addr(rx_addr),
    .in_data(rx_data), .dev_done(svc_rsp_valid), .dev_data(svc_rsp_data),
    .reply_sent(reply_sent), .idle(slot_idle), .wait_dev(slot_wait),
    .reply_pend(reply_pend), .s_src(s_src), .s_thread(s_thread),
    .s_store(s_store), .s_addr(s_addr), .s_data(s_data));

  assign svc_req_valid  = slot_wait;
  assign svc_req_thread = s_thread;
  assign svc_req_store  = s_store;
  assign svc_req_addr   = s_addr;
  assign svc_req_data   = s_data;

  // Output select: reply first unless a queued request is already on show.
  assign sel_reply    = reply_pend && !hold_fifo;
  assign net_tx_valid = sel_reply || !fifo_empty;
  assign net_tx_dest  = sel_reply ? s_src : HOST_ID;
  assign net_tx_msg   = sel_reply ? pack_msg(1'b1, OWN_ID, s_thread, s_store, s_addr, s_data)
                                  : fifo_head;
  assign reply_sent   = sel_reply && net_tx_consumed;
  assign fifo_pop     = !sel_reply && !fifo_empty && net_tx_consumed;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_fifo <= 1'b0;
    else        hold_fifo <= !sel_reply && !fifo_empty && !net_tx_consumed;
  end
endmodule

// File: rtl/io_bridge_chk.sv
module io_bridge_chk #(
  parameter int TILE_W      = 4,
  parameter int MSG_W       = 40,
  parameter int CNT_W       = 3,
  parameter int QUEUE_DEPTH = 4,
  parameter int TILE_ID     = 3,
  parameter int HOST_TILE   = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_avail,
  input logic              fifo_push,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              net_tx_valid,
  input logic [TILE_W-1:0] net_tx_dest,
  input logic [MSG_W-1:0]  net_tx_msg,
  input logic              net_tx_consumed,
  input logic              net_rx_valid,
  input logic              rx_is_reply,
  input logic [TILE_W-1:0] rx_src,
  input logic              net_rx_consumed,
  input logic              core_rsp_valid,
  input logic              svc_req_valid
);
  logic              tx_is_reply;
  logic [TILE_W-1:0] tx_src;
  logic [TILE_W-1:0] exp_reply_dest;
  assign tx_is_reply = net_tx_msg[MSG_W-1];
  assign tx_src      = net_tx_msg[MSG_W-2 -: TILE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) exp_reply_dest <= '0;
    else if (net_rx_valid && !rx_is_reply && net_rx_consumed) exp_reply_dest <= rx_src;
  end

  assert_avail_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !core_avail |-> !fifo_push);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> fifo_count < CNT_W'(QUEUE_DEPTH));
  assert_req_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    net_tx_valid && !tx_is_reply |-> tx_src == TILE_W'(TILE_ID));
  assert_req_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    net_tx_valid && !tx_is_reply |-> net_tx_dest == TILE_W'(HOST_TILE));
  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    net_tx_valid && !net_tx_consumed |=>
      net_tx_valid && $stable(net_tx_msg) && $stable(net_tx_dest));
  assert_rsp_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    net_rx_valid && rx_is_reply |-> net_rx_consumed);
  assert_rsp_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    net_rx_valid && rx_is_reply |=> core_rsp_valid);
  assert_reply_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    net_tx_valid && tx_is_reply |-> net_tx_dest == exp_reply_dest);
  assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req_valid && net_rx_valid && !rx_is_reply |-> !net_rx_consumed);
endmodule

bind io_msg_bridge io_bridge_chk #(
  .TILE_W(TILE_W), .MSG_W(MSG_W), .CNT_W(CNT_W), .QUEUE_DEPTH(QUEUE_DEPTH),
  .TILE_ID(TILE_ID), .HOST_TILE(HOST_TILE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_avail(core_avail), .fifo_push(fifo_push),
  .fifo_count(fifo_count), .net_tx_valid(net_tx_valid), .net_tx_dest(net_tx_dest),
  .net_tx_msg(net_tx_msg), .net_tx_consumed(net_tx_consumed),
  .net_rx_valid(net_rx_valid), .rx_is_reply(rx_is_reply), .rx_src(rx_src),
  .net_rx_consumed(net_rx_consumed), .core_rsp_valid(core_rsp_valid),
  .svc_req_valid(svc_req_valid)
);

// File: tb/sim_io_msg_bridge.sv
module sim_io_msg_bridge;
  localparam int TW = 4, HW = 2, AW = 16, DW = 16, QD = 4, AFM = 1;
  localparam int OWN = 3, HOST = 0;
  localparam int MW = 2 + TW + HW + AW + DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_req_valid = 0, core_req_store = 0;
  logic [HW-1:0] core_req_thread = '0;
  logic [AW-1:0] core_req_addr = '0;
  logic [DW-1:0] core_req_data = '0;
  logic core_avail, core_rsp_valid;
  logic [HW-1:0] core_rsp_thread;
  logic [DW-1:0] core_rsp_data;
  logic net_tx_valid, net_tx_consumed = 0;
  logic [TW-1:0] net_tx_dest;
  logic [MW-1:0] net_tx_msg;
  logic net_rx_valid = 0, net_rx_consumed;
  logic [MW-1:0] net_rx_msg = '0;
  logic svc_req_valid, svc_req_store, svc_rsp_valid = 0;
  logic [HW-1:0] svc_req_thread;
  logic [AW-1:0] svc_req_addr;
  logic [DW-1:0] svc_req_data, svc_rsp_data = '0;

  int n_vec = 0, n_bad = 0;

  io_msg_bridge #(.TILE_W(TW), .THREAD_W(HW), .ADDR_W(AW), .DATA_W(DW),
    .QUEUE_DEPTH(QD), .AF_MARGIN(AFM), .TILE_ID(OWN), .HOST_TILE(HOST)) u0 (
    .clk(clk), .rst_n(rst_n), .core_req_valid(core_req_valid),
    .core_req_thread(core_req_thread), .core_req_store(core_req_store),
    .core_req_addr(core_req_addr), .core_req_data(core_req_data),
    .core_avail(core_avail), .core_rsp_valid(core_rsp_valid),
    .core_rsp_thread(core_rsp_thread), .core_rsp_data(core_rsp_data),
    .net_tx_valid(net_tx_valid), .net_tx_dest(net_tx_dest), .net_tx_msg(net_tx_msg),
    .net_tx_consumed(net_tx_consumed), .net_rx_valid(net_rx_valid),
    .net_rx_msg(net_rx_msg), .net_rx_consumed(net_rx_consumed),
    .svc_req_valid(svc_req_valid), .svc_req_thread(svc_req_thread),
    .svc_req_store(svc_req_store), .svc_req_addr(svc_req_addr),
    .svc_req_data(svc_req_data), .svc_rsp_valid(svc_rsp_valid),
    .svc_rsp_data(svc_rsp_data));

  always #5 clk = ~clk;

  // Field order from R2, MSB first.
  function automatic logic [MW-1:0] mk(input int r, input int s, input int t,
                                       input int o, input int a, input int d);
    return {1'(r), TW'(s), HW'(t), 1'(o), AW'(a), DW'(d)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic settle(); #1; endtask

  task automatic push(input int t, input int o, input int a, input int d);
    core_req_valid = 1; core_req_thread = HW'(t); core_req_store = 1'(o);
    core_req_addr = AW'(a); core_req_data = DW'(d);
    tick(); core_req_valid = 0;
  endtask

  task automatic consume();
    net_tx_consumed = 1; tick(); net_tx_consumed = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; settle();
    chk("R1 avail", core_avail, 1);
    chk("R1 tx_valid", net_tx_valid, 0);
    chk("R1 rsp_valid", core_rsp_valid, 0);
    chk("R1 rx_consumed", net_rx_consumed, 0);
    chk("R1 svc_valid", svc_req_valid, 0);

    // R2 / R4: every thread and op, one at a time
    for (int t = 0; t < 4; t++)
      for (int o = 0; o < 2; o++) begin
        push(t, o, 16'h1000 + t * 16 + o, 16'hA500 ^ (t * 7 + o));
        settle();
        chk("R4 tx_valid", net_tx_valid, 1);
        chk("R4 dest", net_tx_dest, HOST);
        chk("R2 msg", net_tx_msg, mk(0, OWN, t, o, 16'h1000 + t * 16 + o, 16'hA500 ^ (t * 7 + o)));
        consume(); settle();
        chk("R4 popped", net_tx_valid, 0);
      end

    // R3: fill to the almost-full level, then a dropped request
    for (int k = 0; k < QD - AFM; k++) begin
      chk("R3 avail before fill", core_avail, 1);
      push(k, k & 1, 16'h2000 + k, 16'h3000 + k);
    end
    settle();
    chk("R3 avail low", core_avail, 0);
    push(3, 1, 16'hDEAD, 16'hBEEF);
    for (int k = 0; k < QD - AFM; k++) begin
      settle();
      chk("R4 order", net_tx_msg, mk(0, OWN, k, k & 1, 16'h2000 + k, 16'h3000 + k));
      chk("R4 dest order", net_tx_dest, HOST);
      consume();
      settle();
      chk("R3 avail after pop", core_avail, 1);
    end
    settle();
    chk("R3 dropped absent", net_tx_valid, 0);

    // R5: replies to the core
    for (int t = 0; t < 4; t++) begin
      net_rx_valid = 1; net_rx_msg = mk(1, 0, t, 0, 16'h44, 16'h5A00 + t);
      settle();
      chk("R5 consumed", net_rx_consumed, 1);
      tick(); net_rx_valid = 0; settle();
      chk("R5 rsp_valid", core_rsp_valid, 1);
      chk("R5 thread", core_rsp_thread, t);
      chk("R5 data", core_rsp_data, 16'h5A00 + t);
      tick();
      chk("R5 one pulse", core_rsp_valid, 0);
    end

    // R9: device answer while idle has no effect
    svc_rsp_valid = 1; svc_rsp_data = 16'h7777; tick(); svc_rsp_valid = 0; settle();
    chk("R9 stray answer", net_tx_valid, 0);

    // R6 / R7 / R9: serve one request from tile 5
    net_rx_valid = 1; net_rx_msg = mk(0, 5, 2, 1, 16'h0ABC, 16'h1234);
    settle();
    chk("R6 consumed idle", net_rx_consumed, 1);
    tick(); net_rx_valid = 0; settle();
    chk("R6 svc_valid", svc_req_valid, 1);
    chk("R6 thread", svc_req_thread, 2);
    chk("R6 store", svc_req_store, 1);
    chk("R6 addr", svc_req_addr, 16'h0ABC);
    chk("R6 data", svc_req_data, 16'h1234);
    net_rx_valid = 1; net_rx_msg = mk(0, 6, 1, 0, 16'h1, 16'h2);
    settle();
    chk("R9 busy not consumed", net_rx_consumed, 0);
    tick(); net_rx_valid = 0;
    chk("R6 svc still valid", svc_req_valid, 1);
    svc_rsp_valid = 1; svc_rsp_data = 16'hC0DE; tick(); svc_rsp_valid = 0; settle();
    chk("R6 svc dropped", svc_req_valid, 0);
    chk("R7 tx_valid", net_tx_valid, 1);
    chk("R7 dest", net_tx_dest, 5);
    chk("R7 msg", net_tx_msg, mk(1, OWN, 2, 1, 16'h0ABC, 16'hC0DE));
    consume(); settle();
    chk("R7 sent", net_tx_valid, 0);

    // R8 case a: queued request already on show goes first
    push(1, 0, 16'h0E00, 16'h0F00);
    net_rx_valid = 1; net_rx_msg = mk(0, 7, 3, 0, 16'h0E10, 16'h0);
    tick(); net_rx_valid = 0;
    svc_rsp_valid = 1; svc_rsp_data = 16'h9191; tick(); svc_rsp_valid = 0; settle();
    chk("R8 held request", net_tx_msg, mk(0, OWN, 1, 0, 16'h0E00, 16'h0F00));
    chk("R8 held dest", net_tx_dest, HOST);
    consume(); settle();
    chk("R8 reply next", net_tx_msg, mk(1, OWN, 3, 0, 16'h0E10, 16'h9191));
    chk("R8 reply dest", net_tx_dest, 7);
    consume(); settle();
    chk("R8 drained a", net_tx_valid, 0);

    // R8 case b: reply on show, later request waits
    net_rx_valid = 1; net_rx_msg = mk(0, 9, 0, 1, 16'h0D00, 16'h0D01);
    tick(); net_rx_valid = 0;
    svc_rsp_valid = 1; svc_rsp_data = 16'h2222; tick(); svc_rsp_valid = 0;
    push(2, 1, 16'h0C00, 16'h0C01);
    settle();
    chk("R8 reply first", net_tx_msg, mk(1, OWN, 0, 1, 16'h0D00, 16'h2222));
    chk("R8 reply first dest", net_tx_dest, 9);
    consume(); settle();
    chk("R8 request after", net_tx_msg, mk(0, OWN, 2, 1, 16'h0C00, 16'h0C01));
    consume(); settle();
    chk("R8 drained b", net_tx_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule